// File: doc/BRIEF.md
# Vector Element Insert and Extract Unit

This unit handles two element moves on a 256-bit vector register value. In insert mode, element zero of the source vector is written into one chosen slot of the old destination vector, and every other slot of the destination passes through unchanged. In pick mode, one chosen element of the source vector is moved down to slot zero, and every bit above that element is cleared. Elements are either 32-bit words or 64-bit doublewords. The index always spans the whole 256-bit register, so eight word slots or four doubleword slots can be addressed.

The surrounding pipeline reads the source and old destination operands from the register file and presents them with a small immediate, a size select and an operation select. Requests use a valid/ready handshake. Results come back one cycle later on a registered valid/ready output. If the consumer stalls, the result is held and new requests are refused until the held result has been taken.

Top module: `vxi_unit`

## Requirements
- R1: While `rsp_valid` is high and `rsp_ready` is low, `rsp_vec` and `rsp_valid` hold their values. `req_ready` is high exactly when no result is held or the held result is being taken in that cycle.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) produces `rsp_valid` high after that edge. Its result appears on `rsp_vec` with one cycle of latency.
- R3: Insert with word size (`req_op`=0, `req_size`=0) writes source bits [31:0] into destination word `req_imm`. Word i occupies bits [32*i+31:32*i].
- R4: Insert with doubleword size (`req_op`=0, `req_size`=1) writes source bits [63:0] into destination doubleword `req_imm[1:0]`. Doubleword i occupies bits [64*i+63:64*i]. `req_imm[2]` has no effect.
- R5: In insert mode, every destination element other than the target slot equals the old destination value, even when the source and destination hold identical data.
- R6: Pick with word size (`req_op`=1, `req_size`=0) places source word `req_imm` into result bits [31:0].
- R7: Pick with doubleword size (`req_op`=1, `req_size`=1) places source doubleword `req_imm[1:0]` into result bits [63:0]. `req_imm[2]` has no effect.
- R8: In pick mode, all result bits above element zero are zero: bits [255:32] for words and bits [255:64] for doublewords.
- R9: Synchronous active-high reset clears `rsp_valid`.
- R10: When a held result is taken and no request is accepted in the same cycle, `rsp_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 1 | 0 = insert, 1 = pick |
| req_size | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| req_imm | input | 3 | Element index immediate |
| src_vec | input | 256 | Source vector operand |
| dst_vec | input | 256 | Old destination vector operand |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_vec | output | 256 | New destination value |

## Verification
Taking a held result and accepting a new request can happen on the same edge. The bench provokes this by keeping `req_valid` high through long runs with `rsp_ready` both high and randomly dropped, so that back-to-back transfers, stalls with a waiting request, and drains all occur. A behavioural model tracks the output register on every clock and judges `req_ready`, `rsp_valid` and `rsp_vec`. A result replaced in the same cycle it is consumed must show the new data one cycle later. A stalled result must not be overwritten by the waiting request.

// File: rtl/vxi_pkg.sv
package vxi_pkg;

    localparam int VLEN    = 256;
    localparam int WORD_W  = 32;
    localparam int DWORD_W = 2 * WORD_W;
    localparam int N_WORDS = VLEN / WORD_W;
    localparam int IDX_W   = $clog2(N_WORDS);

    typedef enum logic {
        OP_INSERT = 1'b0,
        OP_PICK   = 1'b1
    } vop_e;

    typedef enum logic {
        SZ_WORD  = 1'b0,
        SZ_DWORD = 1'b1
    } vsz_e;

    typedef struct packed {
        vop_e             op;
        vsz_e             size;
        logic [IDX_W-1:0] idx;
    } vctl_t;

    // Doubleword slot index taken from the low bits of the immediate
    function automatic logic [IDX_W-2:0] dslot(input logic [IDX_W-1:0] imm);
        return imm[IDX_W-2:0];
    endfunction

endpackage

// File: rtl/vxi_insert.sv
module vxi_insert
    import vxi_pkg::*;
#(
    parameter int VW = vxi_pkg::VLEN,
    parameter int EW = vxi_pkg::WORD_W,
    parameter int IW = $clog2(VW / EW)
) (
    input  vsz_e          size,
    input  logic [IW-1:0] idx,
    input  logic [VW-1:0] src,
    input  logic [VW-1:0] dst,
    output logic [VW-1:0] res
);
    localparam int NW = VW / EW;

    for (genvar g = 0; g < NW; g++) begin : g_lane
        localparam int HALF = g % 2;
        logic hit_w;
        logic hit_d;
        assign hit_w = (size == SZ_WORD)  && (idx == IW'(g));
        assign hit_d = (size == SZ_DWORD) && (idx[IW-2:0] == (IW-1)'(g / 2));
        assign res[g*EW +: EW] = hit_w ? src[EW-1:0] :
                                 hit_d ? src[HALF*EW +: EW] :
                                         dst[g*EW +: EW];
    end

endmodule

// File: rtl/vxi_pick.sv
module vxi_pick
    import vxi_pkg::*;
#(
    parameter int VW = vxi_pkg::VLEN,
    parameter int EW = vxi_pkg::WORD_W,
    parameter int IW = $clog2(VW / EW)
) (
    input  vsz_e          size,
    input  logic [IW-1:0] idx,
    input  logic [VW-1:0] src,
    output logic [VW-1:0] res
);
    localparam int NW = VW / EW;
    localparam int ND = NW / 2;
    localparam int DW = 2 * EW;

    logic [EW-1:0] word_sel;
    logic [DW-1:0] dword_sel;

    always_comb begin
        word_sel = '0;
        for (int i = 0; i < NW; i++) begin
            if (idx == IW'(i)) word_sel = src[i*EW +: EW];
        end
    end

    always_comb begin
        dword_sel = '0;
        for (int i = 0; i < ND; i++) begin
            if (idx[IW-2:0] == (IW-1)'(i)) dword_sel = src[i*DW +: DW];
        end
    end

    always_comb begin
        res = '0;
        if (size == SZ_WORD) res[EW-1:0] = word_sel;
        else                 res[DW-1:0] = dword_sel;
    end

endmodule

// File: rtl/vxi_out_reg.sv
module vxi_out_reg
    import vxi_pkg::*;
#(
    parameter int VW = vxi_pkg::VLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  vctl_t         in_ctl,
    input  logic [VW-1:0] in_vec,
    output logic          out_valid,
    input  logic          out_ready,
    output vctl_t         out_ctl,
    output logic [VW-1:0] out_vec
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            out_vec <= in_vec;
            out_ctl <= in_ctl;
        end
    end

    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

    // R10
    drain_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R9
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

endmodule

// File: rtl/vxi_unit.sv
module vxi_unit
    import vxi_pkg::*;
#(
    parameter int VW = vxi_pkg::VLEN,
    parameter int EW = vxi_pkg::WORD_W,
    parameter int IW = $clog2(VW / EW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic          req_size,
    input  logic [IW-1:0] req_imm,
    input  logic [VW-1:0] src_vec,
    input  logic [VW-1:0] dst_vec,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [VW-1:0] rsp_vec
);
    localparam int NW = VW / EW;
    localparam int ND = NW / 2;
    localparam int DW = 2 * EW;

    vctl_t         req_ctl;
    vctl_t         held_ctl;
    logic [VW-1:0] ins_res;
    logic [VW-1:0] pick_res;
    logic [VW-1:0] next_vec;

    assign req_ctl.op   = vop_e'(req_op);
    assign req_ctl.size = vsz_e'(req_size);
    assign req_ctl.idx  = req_imm;

    vxi_insert #(.VW(VW), .EW(EW), .IW(IW)) i_insert (
        .size (req_ctl.size),
        .idx  (req_imm),
        .src  (src_vec),
        .dst  (dst_vec),
        .res  (ins_res)
    );

    vxi_pick #(.VW(VW), .EW(EW), .IW(IW)) i_pick (
        .size (req_ctl.size),
        .idx  (req_imm),
        .src  (src_vec),
        .res  (pick_res)
    );

    assign next_vec = (req_ctl.op == OP_PICK) ? pick_res : ins_res;

    vxi_out_reg #(.VW(VW)) i_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_ctl    (req_ctl),
        .in_vec    (next_vec),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_ctl   (held_ctl),
        .out_vec   (rsp_vec)
    );

    // Observation helpers for the assertions below
    logic [EW-1:0] rsp_word_at_idx;
    logic [DW-1:0] rsp_dword_at_idx;
    logic [EW-1:0] src_word_at_imm;
    logic [DW-1:0] src_dword_at_imm;
    logic          accept;

    assign accept = req_valid && req_ready;

    always_comb begin
        rsp_word_at_idx = '0;
        src_word_at_imm = '0;
        for (int i = 0; i < NW; i++) begin
            if (held_ctl.idx == IW'(i)) rsp_word_at_idx = rsp_vec[i*EW +: EW];
            if (req_imm == IW'(i))      src_word_at_imm = src_vec[i*EW +: EW];
        end
    end

    always_comb begin
        rsp_dword_at_idx = '0;
        src_dword_at_imm = '0;
        for (int i = 0; i < ND; i++) begin
            if (dslot(held_ctl.idx) == (IW-1)'(i)) rsp_dword_at_idx = rsp_vec[i*DW +: DW];
            if (dslot(req_imm) == (IW-1)'(i))      src_dword_at_imm = src_vec[i*DW +: DW];
        end
    end

    // R2
    accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);

    // R3
    ins_word_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_op && !req_size) |=> (rsp_word_at_idx == $past(src_vec[EW-1:0])));

    // R4
    ins_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_op && req_size) |=> (rsp_dword_at_idx == $past(src_vec[DW-1:0])));

    // R6
    pick_word_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op && !req_size) |=> (rsp_vec[EW-1:0] == $past(src_word_at_imm)));

    // R7
    pick_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op && req_size) |=> (rsp_vec[DW-1:0] == $past(src_dword_at_imm)));

    // R8
    pick_zero_w_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && held_ctl.op == OP_PICK && held_ctl.size == SZ_WORD)
        |-> (rsp_vec[VW-1:EW] == '0));

    // R8
    pick_zero_d_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && held_ctl.op == OP_PICK && held_ctl.size == SZ_DWORD)
        |-> (rsp_vec[VW-1:DW] == '0));

endmodule

// File: tb/test_vxi_unit.sv
module test_vxi_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_op = 1'b0;
    logic         req_size = 1'b0;
    logic [2:0]   req_imm = '0;
    logic [255:0] src_vec = '0;
    logic [255:0] dst_vec = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [255:0] rsp_vec;

    int checks = 0;
    int errors = 0;

    // Behavioural model of the output register
    logic         exp_valid = 1'b0;
    logic [255:0] exp_vec = '0;
    string        exp_tag = "";

    always #4 clk = ~clk;   // 125 MHz

    vxi_unit i_vxi_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_imm(req_imm),
        .src_vec(src_vec), .dst_vec(dst_vec), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_vec(rsp_vec)
    );

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    function automatic logic [255:0] model(input logic op, input logic sz,
                                           input logic [2:0] imm,
                                           input logic [255:0] s, input logic [255:0] d);
        logic [255:0] r;
        int k;
        if (!op) begin
            r = d;
            if (!sz) begin k = int'(imm);     r[k*32 +: 32] = s[31:0]; end
            else     begin k = int'(imm) % 4; r[k*64 +: 64] = s[63:0]; end
        end else begin
            r = '0;
            if (!sz) begin k = int'(imm);     r[31:0] = s[k*32 +: 32]; end
            else     begin k = int'(imm) % 4; r[63:0] = s[k*64 +: 64]; end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic op, input logic sz);
        if (!op) return sz ? "R4 R5" : "R3 R5";
        return sz ? "R7 R8" : "R6 R8";
    endfunction

    task automatic check_out();
        checks++;
        if (rsp_valid !== exp_valid) begin
            errors++;
            $display("FAIL R2 R10 rsp_valid actual %0b expected %0b", rsp_valid, exp_valid);
        end
        if (exp_valid) begin
            checks++;
            if (rsp_vec !== exp_vec) begin
                errors++;
                $display("FAIL %s rsp_vec actual %h expected %h", exp_tag, rsp_vec, exp_vec);
            end
        end
    endtask

    // One cycle: check outputs, drive inputs, check ready, advance model
    task automatic step(input logic v, input logic op, input logic sz,
                        input logic [2:0] imm, input logic [255:0] s,
                        input logic [255:0] d, input logic rr);
        logic rdy;
        @(negedge clk);
        check_out();
        req_valid = v; req_op = op; req_size = sz; req_imm = imm;
        src_vec = s; dst_vec = d; rsp_ready = rr;
        #1;
        rdy = !exp_valid || rr;
        checks++;
        if (req_ready !== rdy) begin
            errors++;
            $display("FAIL R1 req_ready actual %0b expected %0b", req_ready, rdy);
        end
        if (rdy) begin
            if (v) begin
                exp_valid = 1'b1;
                exp_vec = model(op, sz, imm, s, d);
                exp_tag = tag_of(op, sz);
            end else begin
                exp_valid = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual hung expected completion");
        finish_run();
    end

    initial begin : stimulus
        logic [255:0] same;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 rsp_valid after reset actual %0b expected 0", rsp_valid);
        end

        // Every index, both sizes, both operations (R3 R4 R6 R7, imm[2] on dwords)
        for (int op = 0; op < 2; op++)
            for (int sz = 0; sz < 2; sz++)
                for (int i = 0; i < 8; i++)
                    step(1'b1, op[0], sz[0], 3'(i), rnd_vec(), rnd_vec(), 1'b1);

        // R5: insert with identical source and destination data
        for (int sz = 0; sz < 2; sz++)
            for (int i = 0; i < 8; i++) begin
                same = rnd_vec();
                step(1'b1, 1'b0, sz[0], 3'(i), same, same, 1'b1);
            end

        // R1: stall with a waiting request, then release
        step(1'b1, 1'b1, 1'b0, 3'd5, rnd_vec(), rnd_vec(), 1'b0);
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 1'b1, 3'(k), rnd_vec(), rnd_vec(), 1'b0);
        step(1'b1, 1'b0, 1'b0, 3'd7, rnd_vec(), rnd_vec(), 1'b1);

        // R10: drain with no new request
        step(1'b0, 1'b0, 1'b0, 3'd0, '0, '0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 3'd0, '0, '0, 1'b1);

        // Mixed traffic with random back-pressure
        for (int k = 0; k < 4000; k++)
            step(($urandom() % 4) != 0, 1'($urandom()), 1'($urandom()), 3'($urandom()),
                 rnd_vec(), rnd_vec(), ($urandom() % 3) != 0);

        step(1'b0, 1'b0, 1'b0, 3'd0, '0, '0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 3'd0, '0, '0, 1'b1);
        @(negedge clk);
        check_out();
        finish_run();
    end

endmodule